// File: doc/BRIEF.md
# Event-Synchronized Run-Control Sequencer

This block holds the run state of a data-acquisition system and turns software run commands into the enable signals that the timing hardware needs. Its six commands are setup, activate, pause, resume, end and abort. It tracks four run states and drives three kinds of enable: one for the start-pulse generator, one for the trigger interrupt toward the processor, and a vector of subsystem enables.

Activation, pause and resume are not applied when software issues them. Each is held as a pending request and takes effect at the next DAQ-ready timing event, so a change of run state always falls on a cycle boundary of the acquisition. End and abort take effect at once and discard any pending request. While a run is active, a status error input is sampled at each end-of-cycle event. An error ends the run and raises a sticky flag.

A command that is not valid in the current state is ignored and raises a one-cycle pulse. All inputs are single-cycle pulses in the block's clock domain.

Top module: `run_sequencer`

## Requirements
- R1: After reset, run_state is 0 (IDLE) and start_en, trig_irq_en, sub_en, err_flag and illegal_cmd are all 0. The run_state encoding is IDLE=0, READY=1, ACTIVE=2, PAUSED=3.
- R2: cmd_setup in IDLE moves run_state to READY on the next clock edge.
- R3: cmd_activate in READY sets trig_irq_en on the next edge. run_state stays READY, and start_en and sub_en stay 0, until a daq_ready pulse arrives.
- R4: With an activation pending in READY, a daq_ready pulse moves run_state to ACTIVE and sets start_en and every sub_en bit. This includes a daq_ready in the same cycle as cmd_activate. A daq_ready with no pending activation leaves READY unchanged.
- R5: cmd_pause in ACTIVE is held until the next daq_ready, which moves run_state to PAUSED and clears start_en. sub_en and trig_irq_en stay set.
- R6: cmd_resume in PAUSED is held until the next daq_ready, which moves run_state to ACTIVE and sets start_en again. This includes a daq_ready in the same cycle as cmd_resume.
- R7: cmd_end or cmd_abort in READY, ACTIVE or PAUSED returns run_state to IDLE on the next edge and clears all enables. A pending request is discarded, so a later daq_ready has no effect.
- R8: In ACTIVE, cyc_end with status_err set raises err_flag and returns run_state to IDLE with all enables cleared. This wins over any command or daq_ready in the same cycle.
- R9: A cyc_end with status_err set while PAUSED changes neither run_state nor err_flag.
- R10: err_flag is sticky. It is cleared only by an accepted cmd_setup, or by err_clear while in IDLE.
- R11: When several commands arrive in one cycle, only the highest-priority one is considered. The priority is abort or end, then setup, activate, pause, resume. If that command is invalid in the current state, it is ignored and illegal_cmd is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_setup | input | 1 | Setup command pulse |
| cmd_activate | input | 1 | Activate command pulse |
| cmd_pause | input | 1 | Pause command pulse |
| cmd_resume | input | 1 | Resume command pulse |
| cmd_end | input | 1 | End-of-run command pulse |
| cmd_abort | input | 1 | Abort command pulse |
| err_clear | input | 1 | Clears err_flag while in IDLE |
| daq_ready | input | 1 | DAQ-ready timing event pulse |
| cyc_end | input | 1 | End-of-cycle event pulse |
| status_err | input | 1 | Status error level, sampled at cyc_end |
| start_en | output | 1 | Start-pulse generator enable |
| trig_irq_en | output | 1 | Trigger-to-processor interrupt enable |
| sub_en | output | SUB_W | Subsystem enables |
| run_state | output | 2 | Current run state |
| err_flag | output | 1 | Sticky run error flag |
| illegal_cmd | output | 1 | One-cycle pulse for a rejected command |

## Verification
The hardest situations to reach are the ones where several inputs coincide in one cycle. Examples are a command together with the daq_ready that consumes it, an end-of-cycle error together with a pause and a daq_ready, and a pending pause that an abort cancels before its event arrives. A stepping task drives any mix of commands and events in a single cycle, so directed steps place each of these coincidences exactly. A stretch of pseudo-random sparse pulses then follows, and a behavioural model checks every cycle of it.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    RS_IDLE   = 2'd0,
    RS_READY  = 2'd1,
    RS_ACTIVE = 2'd2,
    RS_PAUSED = 2'd3
  } rs_state_e;

  typedef enum logic [2:0] {
    C_NONE   = 3'd0,
    C_STOP   = 3'd1,
    C_SETUP  = 3'd2,
    C_ACT    = 3'd3,
    C_PAUSE  = 3'd4,
    C_RESUME = 3'd5
  } rs_cmd_e;

  localparam int CMD_W    = 6;
  localparam int B_SETUP  = 0;
  localparam int B_ACT    = 1;
  localparam int B_PAUSE  = 2;
  localparam int B_RESUME = 3;
  localparam int B_END    = 4;
  localparam int B_ABORT  = 5;
endpackage

// File: rtl/rs_cmd_arb.sv
module rs_cmd_arb
  import rs_pkg::*;
(
  input  logic [CMD_W-1:0] cmd_vec,
  input  rs_state_e        state_q,
  output rs_cmd_e          cmd,
  output logic             cmd_ok,
  output logic             cmd_bad
);
  // priority pick: stop (end/abort) > setup > activate > pause > resume (R11)
  always_comb begin
    cmd = C_NONE;
    if (cmd_vec[B_ABORT] || cmd_vec[B_END]) cmd = C_STOP;
    else if (cmd_vec[B_SETUP])              cmd = C_SETUP;
    else if (cmd_vec[B_ACT])                cmd = C_ACT;
    else if (cmd_vec[B_PAUSE])              cmd = C_PAUSE;
    else if (cmd_vec[B_RESUME])             cmd = C_RESUME;
  end

  always_comb begin
    unique case (cmd)
      C_STOP:   cmd_ok = (state_q != RS_IDLE);
      C_SETUP:  cmd_ok = (state_q == RS_IDLE);
      C_ACT:    cmd_ok = (state_q == RS_READY);
      C_PAUSE:  cmd_ok = (state_q == RS_ACTIVE);
      C_RESUME: cmd_ok = (state_q == RS_PAUSED);
      default:  cmd_ok = 1'b0;
    endcase
    cmd_bad = (cmd != C_NONE) && !cmd_ok;
  end
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  rs_cmd_e   cmd,
  input  logic      cmd_ok,
  input  logic      cmd_bad,
  input  logic      daq_ready,
  input  logic      cyc_end,
  input  logic      status_err,
  input  logic      err_clear,
  output rs_state_e state_q,
  output logic      pend_q,
  output logic      err_q,
  output logic      bad_q
);
  rs_state_e state_d;
  logic      pend_d, pend_arm, fault;
  logic      err_set, err_clr, err_en, err_d;

  always_comb begin
    state_d  = state_q;
    pend_d   = pend_q;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    pend_arm = pend_q;
    fault    = (state_q == RS_ACTIVE) && cyc_end && status_err;
    if (fault) begin
      state_d = RS_IDLE;
      pend_d  = 1'b0;
      err_set = 1'b1;
    end else if (cmd_ok && cmd == C_STOP) begin
      state_d = RS_IDLE;
      pend_d  = 1'b0;
    end else if (cmd_ok && cmd == C_SETUP) begin
      state_d = RS_READY;
      err_clr = 1'b1;
    end else begin
      pend_arm = pend_q || (cmd_ok && (cmd == C_ACT || cmd == C_PAUSE || cmd == C_RESUME));
      if (daq_ready && pend_arm) begin
        pend_d  = 1'b0;
        state_d = (state_q == RS_ACTIVE) ? RS_PAUSED : RS_ACTIVE;
      end else begin
        pend_d = pend_arm;
      end
    end
    if (err_clear && state_q == RS_IDLE) err_clr = 1'b1;
    err_en = err_set || err_clr;
    err_d  = err_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      bad_q   <= cmd_bad;
      if (err_en) err_q <= err_d;
    end
  end

  // R2: IDLE is only ever left toward READY
  assert_idle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == RS_IDLE && state_q != RS_IDLE) |-> state_q == RS_READY);
  // R4 / R6: entry into ACTIVE from READY or PAUSED only on a DAQ-ready event
  assert_active_on_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_ACTIVE && ($past(state_q) == RS_READY || $past(state_q) == RS_PAUSED))
      |-> $past(daq_ready));
  // R5: pause lands only on a DAQ-ready event
  assert_pause_on_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_PAUSED && $past(state_q) == RS_ACTIVE) |-> $past(daq_ready));
  // R8: end-of-cycle error in ACTIVE forces IDLE with the flag set
  assert_fault_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_ACTIVE && cyc_end && status_err) |=> (state_q == RS_IDLE && err_q));
  // R10: the sticky flag only drops while in IDLE
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(state_q) == RS_IDLE);
endmodule

// File: rtl/rs_outdec.sv
module rs_outdec
  import rs_pkg::*;
#(
  parameter int SUB_W = 4
) (
  input  rs_state_e        state_q,
  input  logic             pend_q,
  output logic             start_en,
  output logic             trig_irq_en,
  output logic [SUB_W-1:0] sub_en,
  output logic [1:0]       run_state
);
  logic running;

  always_comb begin
    running     = (state_q == RS_ACTIVE) || (state_q == RS_PAUSED);
    start_en    = (state_q == RS_ACTIVE);
    trig_irq_en = running || (state_q == RS_READY && pend_q);
    run_state   = state_q;
  end

  for (genvar g = 0; g < SUB_W; g++) begin : g_sub
    assign sub_en[g] = running;
  end
endmodule

// File: rtl/run_sequencer.sv
module run_sequencer
  import rs_pkg::*;
#(
  parameter int SUB_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_setup,
  input  logic             cmd_activate,
  input  logic             cmd_pause,
  input  logic             cmd_resume,
  input  logic             cmd_end,
  input  logic             cmd_abort,
  input  logic             err_clear,
  input  logic             daq_ready,
  input  logic             cyc_end,
  input  logic             status_err,
  output logic             start_en,
  output logic             trig_irq_en,
  output logic [SUB_W-1:0] sub_en,
  output logic [1:0]       run_state,
  output logic             err_flag,
  output logic             illegal_cmd
);
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;
  logic [CMD_W-1:0]       cmd_vec;
  rs_cmd_e                cmd;
  logic                   cmd_ok, cmd_bad, pend_q;
  rs_state_e              state_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  always_comb begin
    cmd_vec           = '0;
    cmd_vec[B_SETUP]  = cmd_setup;
    cmd_vec[B_ACT]    = cmd_activate;
    cmd_vec[B_PAUSE]  = cmd_pause;
    cmd_vec[B_RESUME] = cmd_resume;
    cmd_vec[B_END]    = cmd_end;
    cmd_vec[B_ABORT]  = cmd_abort;
  end

  rs_cmd_arb u_arb (
    .cmd_vec (cmd_vec),
    .state_q (state_q),
    .cmd     (cmd),
    .cmd_ok  (cmd_ok),
    .cmd_bad (cmd_bad)
  );

  rs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cmd        (cmd),
    .cmd_ok     (cmd_ok),
    .cmd_bad    (cmd_bad),
    .daq_ready  (daq_ready),
    .cyc_end    (cyc_end),
    .status_err (status_err),
    .err_clear  (err_clear),
    .state_q    (state_q),
    .pend_q     (pend_q),
    .err_q      (err_flag),
    .bad_q      (illegal_cmd)
  );

  rs_outdec #(.SUB_W(SUB_W)) u_out (
    .state_q     (state_q),
    .pend_q      (pend_q),
    .start_en    (start_en),
    .trig_irq_en (trig_irq_en),
    .sub_en      (sub_en),
    .run_state   (run_state)
  );
endmodule

// File: tb/run_sequencer_tb_top.sv
module run_sequencer_tb_top;
  localparam int SUB_W = 4;
  localparam int WD_LIMIT = 50000;

  logic clk, rst_n;
  logic c_setup, c_act, c_pause, c_resume, c_end, c_abort;
  logic eclr, rdy, cend, serr;
  logic start_en, trig_irq_en, err_flag, illegal_cmd;
  logic [SUB_W-1:0] sub_en;
  logic [1:0] run_state;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  run_sequencer #(.SUB_W(SUB_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_setup(c_setup), .cmd_activate(c_act), .cmd_pause(c_pause),
    .cmd_resume(c_resume), .cmd_end(c_end), .cmd_abort(c_abort),
    .err_clear(eclr), .daq_ready(rdy), .cyc_end(cend), .status_err(serr),
    .start_en(start_en), .trig_irq_en(trig_irq_en), .sub_en(sub_en),
    .run_state(run_state), .err_flag(err_flag), .illegal_cmd(illegal_cmd)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // behavioural reference: state as integer, pending as a flag
  int  m_st;
  bit  m_pend, m_err, m_ill;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_pend = 0; m_err = 0; m_ill = 0;
    end else begin
      int sel; bit ok; int old;
      old = m_st;
      sel = (c_abort || c_end) ? 4 : c_setup ? 0 : c_act ? 1 : c_pause ? 2 : c_resume ? 3 : -1;
      case (sel)
        4: ok = (m_st != 0);
        0: ok = (m_st == 0);
        1: ok = (m_st == 1);
        2: ok = (m_st == 2);
        3: ok = (m_st == 3);
        default: ok = 0;
      endcase
      m_ill = (sel >= 0) && !ok;
      if (m_st == 2 && cend && serr) begin
        m_st = 0; m_pend = 0; m_err = 1;
      end else if (ok && sel == 4) begin
        m_st = 0; m_pend = 0;
      end else if (ok && sel == 0) begin
        m_st = 1; m_err = 0;
      end else begin
        if (ok) m_pend = 1;
        if (rdy && m_pend) begin
          m_st = (m_st == 2) ? 3 : 2;
          m_pend = 0;
        end
      end
      if (eclr && old == 0) m_err = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 run_state vs model", run_state, m_st);
      chk("R4 start_en vs model", start_en, (m_st == 2));
      chk("R3 trig_irq_en vs model", trig_irq_en, (m_st >= 2) || (m_st == 1 && m_pend));
      chk("R7 sub_en vs model", sub_en, (m_st >= 2) ? {SUB_W{1'b1}} : '0);
      chk("R10 err_flag vs model", err_flag, m_err);
      chk("R11 illegal_cmd vs model", illegal_cmd, m_ill);
    end
    cycles++;
    if (cycles > WD_LIMIT && !done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WD_LIMIT);
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [5:0] K_SET = 6'b000001, K_ACT = 6'b000010, K_PAU = 6'b000100,
                         K_RES = 6'b001000, K_END = 6'b010000, K_ABT = 6'b100000;

  task automatic step(input logic [5:0] c, input logic r, input logic e,
                      input logic s, input logic x);
    {c_abort, c_end, c_resume, c_pause, c_act, c_setup} = c;
    rdy = r; cend = e; serr = s; eclr = x;
    @(negedge clk); #1;
    {c_abort, c_end, c_resume, c_pause, c_act, c_setup} = '0;
    rdy = 0; cend = 0; serr = 0; eclr = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    rst_n = 0;
    {c_abort, c_end, c_resume, c_pause, c_act, c_setup} = '0;
    rdy = 0; cend = 0; serr = 0; eclr = 0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk); #1;
    // R1 reset state
    chk("R1 state", run_state, 0); chk("R1 start_en", start_en, 0);
    chk("R1 trig", trig_irq_en, 0); chk("R1 sub_en", sub_en, 0);
    chk("R1 err", err_flag, 0); chk("R1 illegal", illegal_cmd, 0);
    // R11 invalid command in IDLE
    step(K_ACT, 0, 0, 0, 0);
    chk("R11 illegal pulse", illegal_cmd, 1); chk("R11 state held", run_state, 0);
    step(0, 0, 0, 0, 0);
    chk("R11 pulse one cycle", illegal_cmd, 0);
    // R2
    step(K_SET, 0, 0, 0, 0);
    chk("R2 to READY", run_state, 1);
    // R4 event without pending activation
    step(0, 1, 0, 0, 0);
    chk("R4 no pending stays READY", run_state, 1); chk("R4 trig off", trig_irq_en, 0);
    // R3
    step(K_ACT, 0, 0, 0, 0);
    chk("R3 trig on", trig_irq_en, 1); chk("R3 still READY", run_state, 1);
    chk("R3 start off", start_en, 0);
    step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    chk("R4 ACTIVE", run_state, 2); chk("R4 start", start_en, 1);
    chk("R4 sub", sub_en, {SUB_W{1'b1}});
    // R5
    step(K_PAU, 0, 0, 0, 0);
    chk("R5 pending not applied", run_state, 2);
    step(0, 0, 1, 0, 0);
    chk("R5 clean end event", run_state, 2);
    step(0, 1, 0, 0, 0);
    chk("R5 PAUSED", run_state, 3); chk("R5 start off", start_en, 0);
    chk("R5 trig kept", trig_irq_en, 1); chk("R5 sub kept", sub_en, {SUB_W{1'b1}});
    // R9
    step(0, 0, 1, 1, 0);
    chk("R9 paused ignores error", run_state, 3); chk("R9 err stays 0", err_flag, 0);
    // R6 same-cycle resume and event
    step(K_RES, 1, 0, 0, 0);
    chk("R6 ACTIVE", run_state, 2); chk("R6 start", start_en, 1);
    // R7 abort discards pending pause
    step(K_PAU, 0, 0, 0, 0);
    step(K_ABT, 0, 0, 0, 0);
    chk("R7 IDLE", run_state, 0); chk("R7 trig off", trig_irq_en, 0); chk("R7 sub off", sub_en, 0);
    step(0, 1, 0, 0, 0);
    chk("R7 pending discarded", run_state, 0);
    // R11 priority setup over activate
    step(K_SET | K_ACT, 0, 0, 0, 0);
    chk("R11 priority state", run_state, 1); chk("R11 no illegal", illegal_cmd, 0);
    chk("R11 activate dropped", trig_irq_en, 0);
    // R4 same-cycle activate and event
    step(K_ACT, 1, 0, 0, 0);
    chk("R4 same-cycle ACTIVE", run_state, 2);
    // R8 error wins over pause and event
    step(K_PAU, 1, 1, 1, 0);
    chk("R8 IDLE", run_state, 0); chk("R8 err", err_flag, 1); chk("R8 start off", start_en, 0);
    step(0, 0, 0, 0, 0);
    chk("R10 sticky", err_flag, 1);
    step(0, 0, 0, 0, 1);
    chk("R10 err_clear in IDLE", err_flag, 0);
    step(K_SET, 0, 0, 0, 0);
    step(K_ACT, 1, 0, 0, 0);
    step(0, 0, 1, 1, 0);
    chk("R8 error again", err_flag, 1);
    step(K_SET, 0, 0, 0, 0);
    chk("R10 setup clears", err_flag, 0); chk("R10 READY", run_state, 1);
    // R7 end from READY with activation pending
    step(K_ACT, 0, 0, 0, 0);
    step(K_END, 0, 0, 0, 0);
    chk("R7 end from READY", run_state, 0); chk("R7 trig cleared", trig_irq_en, 0);
    step(K_END, 0, 0, 0, 0);
    chk("R11 end in IDLE illegal", illegal_cmd, 1);
    step(K_SET, 0, 0, 0, 0);
    step(K_ACT, 1, 0, 0, 0);
    step(K_RES, 0, 0, 0, 0);
    chk("R11 resume in ACTIVE illegal", illegal_cmd, 1); chk("R11 ACTIVE kept", run_state, 2);
    step(K_PAU | K_END, 0, 0, 0, 0);
    chk("R7 end beats pause", run_state, 0);
    // sparse pseudo-random traffic, model-checked every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] c;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c = (lfsr[3:0] == 0) ? (6'b1 << (lfsr[7:5] % 6)) : 6'b0;
      if (lfsr[11:8] == 4'hF) c = 6'b0;
      step(c, lfsr[9] & lfsr[4], lfsr[12] & lfsr[2], lfsr[14] & lfsr[13] & lfsr[1],
           lfsr[15] & lfsr[0] & lfsr[6]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule